// File: doc/BRIEF.md
# Multi-Processor Hardware Mutex Bank

This block is a bank of hardware locks shared by several processors on one chip. Each lock is a 32-bit register that holds the ID of its current owner, or zero when it is free. A processor claims a lock by writing its own nonzero ID into the lock's register. The lock takes that write only while it is free. The processor then reads the register back: the claim succeeded only if the value read equals its own ID. Writing zero frees the lock.

Each processor reaches the bank through its own simple register port. A port has a byte address, a write enable, write data, a read enable and read data. The lock registers sit on a wide fixed stride of 128 bytes inside a 4 KiB window. Only the first word of each stride slot is live. When several ports write the same lock in one cycle, a fixed priority settles the result. Any holder can be observed by every processor, so software can detect a release attempted by a processor that does not own the lock.

Top module: `hwmtx_bank`

## Requirements
- R1: A nonzero write to a lock that holds 0 stores the written value as the owner ID, visible on the next read.
- R2: A nonzero write to a lock that holds a nonzero ID is ignored, and the existing owner ID is kept.
- R3: A write of 0 to a lock frees it (the lock then reads 0), whichever port issues the write and whoever owns the lock.
- R4: Every port reads the current owner ID of a lock, whether or not that port owns it. Read data appears on `rdata_o` one clock after the cycle in which `re_i` is high, and reflects the lock state before any write in that same cycle.
- R5: Lock i is addressed at byte offset i*128, that is address bits [11:7] = i and bits [6:0] = 0.
- R6: An access whose address bits [6:0] are nonzero reads 0, and a write to it changes no lock.
- R7: An access to a lock index at or above NUM_LOCKS reads 0, and a write to it changes no lock.
- R8: After an active-low reset every lock reads 0.
- R9: When several ports write the same lock in one cycle, only the write from the lowest-numbered port takes effect. The writes from the other ports are ignored, even if they would free the lock.
- R10: `rdata_o` of a port is 0 in the cycle after one in which that port's `re_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | NUM_PORTS*ADDR_W | Byte address per port; port p uses slice p |
| we_i | input | NUM_PORTS | Write enable per port |
| wdata_i | input | NUM_PORTS*32 | Write data per port: an owner ID, or 0 to release |
| re_i | input | NUM_PORTS | Read enable per port |
| rdata_o | output | NUM_PORTS*32 | Registered read data per port |

## Verification
The bench builds the bank with NUM_LOCKS = 4 and NUM_PORTS = 3, and keeps the full 12-bit address. This leaves 28 unused lock slots in the window, so the bench can sweep every out-of-range index and both sides of the count boundary. With three ports, every claim, block and release can be tried from each port against each lock. The bench also drives triple same-cycle collisions, which shows that the priority order holds past a single pair. A sweep over every 4-byte offset inside a stride slot covers the dead words of each lock.

// File: rtl/hwmtx_pkg.sv
package hwmtx_pkg;
  localparam int ID_W = 32;
  typedef logic [ID_W-1:0] id_t;
  localparam id_t ID_FREE = '0;
endpackage

// File: rtl/hwmtx_decode.sv
module hwmtx_decode #(
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 7,
  parameter int NUM_LOCKS  = 32,
  localparam int IDX_W     = ADDR_W - STRIDE_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign idx_o = addr_i[ADDR_W-1:STRIDE_LSB];
  // only the first word of each slot maps to a lock
  assign hit_o = (addr_i[STRIDE_LSB-1:0] == '0) && (int'(idx_o) < NUM_LOCKS);
endmodule

// File: rtl/hwmtx_lock.sv
module hwmtx_lock
  import hwmtx_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS-1:0]      sel_i,
  input  logic [NUM_PORTS*ID_W-1:0] wdata_i,
  output id_t                       owner_o
);
  id_t  owner_q, win_d;
  logic win_v, take, clr;

  // lowest port index wins
  always_comb begin
    win_v = 1'b0;
    win_d = ID_FREE;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (sel_i[p]) begin
        win_v = 1'b1;
        win_d = wdata_i[p*ID_W +: ID_W];
      end
    end
  end

  assign take = win_v && (win_d != ID_FREE) && (owner_q == ID_FREE);
  assign clr  = win_v && (win_d == ID_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   owner_q <= ID_FREE;
    else if (clr)  owner_q <= ID_FREE;
    else if (take) owner_q <= win_d;
  end

  assign owner_o = owner_q;

  AST_HELD_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != ID_FREE && !(sel_i != '0 && win_d == ID_FREE)) |=> owner_q == $past(owner_q)); // R2
  AST_FREE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == ID_FREE && sel_i != '0 && win_d != ID_FREE) |=> owner_q == $past(win_d)); // R1
  AST_ZERO_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != '0 && win_d == ID_FREE) |=> owner_q == ID_FREE); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> $stable(owner_q)); // R9
endmodule

// File: rtl/hwmtx_bank.sv
module hwmtx_bank
  import hwmtx_pkg::*;
#(
  parameter int NUM_LOCKS    = 32,
  parameter int NUM_PORTS    = 2,
  parameter int ADDR_W       = 12,
  parameter int STRIDE_BYTES = 128
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS*ID_W-1:0]   wdata_i,
  input  logic [NUM_PORTS-1:0]        re_i,
  output logic [NUM_PORTS*ID_W-1:0]   rdata_o
);
  localparam int STRIDE_LSB = $clog2(STRIDE_BYTES);
  localparam int IDX_W      = ADDR_W - STRIDE_LSB;

  logic [NUM_PORTS-1:0] hit;
  logic [IDX_W-1:0]     idx [NUM_PORTS];
  id_t                  owner [NUM_LOCKS];
  id_t                  rd_q [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hwmtx_decode #(
      .ADDR_W(ADDR_W), .STRIDE_LSB(STRIDE_LSB), .NUM_LOCKS(NUM_LOCKS)
    ) u_dec (
      .addr_i(addr_i[p*ADDR_W +: ADDR_W]),
      .hit_o (hit[p]),
      .idx_o (idx[p])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rd_q[p] <= ID_FREE;
      else if (re_i[p] && hit[p]) rd_q[p] <= owner[idx[p]];
      else                        rd_q[p] <= ID_FREE;
    end

    assign rdata_o[p*ID_W +: ID_W] = rd_q[p];

    AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i[p] && !hit[p]) |=> rd_q[p] == ID_FREE); // R7
    AST_IDLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !re_i[p] |=> rd_q[p] == ID_FREE); // R10
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    logic [NUM_PORTS-1:0] sel;
    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        sel[p] = we_i[p] && hit[p] && (int'(idx[p]) == l);
    end

    hwmtx_lock #(.NUM_PORTS(NUM_PORTS)) u_lock (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel),
      .wdata_i(wdata_i),
      .owner_o(owner[l])
    );
  end

  initial begin
    AST_WINDOW_FITS: assert (NUM_LOCKS * STRIDE_BYTES <= (1 << ADDR_W)); // R5
  end
endmodule

// File: tb/sim_hwmtx_bank.sv
module sim_hwmtx_bank;
  localparam int NL = 4;
  localparam int NP = 3;
  localparam int AW = 12;
  localparam int SB = 128;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP-1:0]  we = '0, re = '0;
  logic [NP*32-1:0] wdata = '0;
  logic [NP*32-1:0] rdata;

  int checks = 0, errors = 0;
  logic [31:0] model [NL];

  always #2 clk = ~clk;

  hwmtx_bank #(.NUM_LOCKS(NL), .NUM_PORTS(NP), .ADDR_W(AW), .STRIDE_BYTES(SB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    we = '0; re = '0;
  endtask

  task automatic wr(int p, int a, logic [31:0] d);
    addr[p*AW +: AW] = AW'(a); wdata[p*32 +: 32] = d; we[p] = 1'b1;
    step();
  endtask

  // read from port p, result captured at the edge, sampled after it
  task automatic rd(int p, int a, output logic [31:0] v);
    addr[p*AW +: AW] = AW'(a); re[p] = 1'b1;
    step();
    v = rdata[p*32 +: 32];
  endtask

  task automatic verify_all(string req);
    logic [31:0] v;
    for (int l = 0; l < NL; l++) begin
      rd(l % NP, l * SB, v);
      chk(req, v, model[l]);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int l = 0; l < NL; l++) model[l] = '0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    verify_all("R8");
    chk("R10", rdata[31:0], 32'h0);

    // claim / block / release sweep over locks and ports (R1 R2 R3 R4)
    for (int l = 0; l < NL; l++) begin
      for (int p = 0; p < NP; p++) begin
        logic [31:0] id = 32'h100 * (p + 1) + l;
        int q = (p + 1) % NP;
        wr(p, l * SB, id); model[l] = id;
        for (int r = 0; r < NP; r++) begin
          rd(r, l * SB, v); chk("R1/R4", v, id);
        end
        wr(q, l * SB, 32'hBAD0 + q); // R2 ignored
        rd(q, l * SB, v); chk("R2", v, id);
        wr(q, l * SB, 32'h0); model[l] = '0; // R3 non-owner release
        rd(p, l * SB, v); chk("R3", v, 32'h0);
      end
    end

    // R10: read-enable low gives zero even when lock held
    wr(0, 1 * SB, 32'h55); model[1] = 32'h55;
    addr[0 +: AW] = AW'(1 * SB); step();
    chk("R10", rdata[31:0], 32'h0);

    // R6: every other word in each slot is dead
    for (int l = 0; l < NL; l++) begin
      for (int o = 4; o < SB; o += 4) begin
        wr(2, l * SB + o, 32'h0);      // would free if mapped
        wr(1, l * SB + o, 32'h77);
        rd(0, l * SB + o, v); chk("R6", v, 32'h0);
      end
    end
    verify_all("R6");

    // R7: indices at or above the count
    for (int i = NL; i < (1 << AW) / SB; i++) begin
      wr(0, i * SB, 32'h99);
      rd(1, i * SB, v); chk("R7", v, 32'h0);
    end
    wr(0, NL * SB, 32'h0);
    verify_all("R7");
    // R5: boundary index NL-1 is live
    wr(2, (NL - 1) * SB, 32'hA5); model[NL-1] = 32'hA5;
    rd(0, (NL - 1) * SB, v); chk("R5", v, 32'hA5);

    // R9: same-cycle collisions on a free lock and on a held lock
    for (int l = 0; l < NL; l++) begin
      if (model[l] != 0) begin wr(0, l * SB, 0); model[l] = 0; end
      for (int p = 0; p < NP; p++) begin
        addr[p*AW +: AW] = AW'(l * SB); wdata[p*32 +: 32] = 32'h10 + p; we[p] = 1'b1;
      end
      step(); model[l] = 32'h10;
      rd(2, l * SB, v); chk("R9 free", v, 32'h10);
      // lower port claims held lock, higher ports release: no change
      addr[0 +: AW] = AW'(l * SB); wdata[0 +: 32] = 32'h44; we[0] = 1'b1;
      addr[AW +: AW] = AW'(l * SB); wdata[32 +: 32] = 32'h0; we[1] = 1'b1;
      step();
      rd(1, l * SB, v); chk("R9 held", v, 32'h10);
      // port 1 release wins over port 2 claim
      addr[AW +: AW] = AW'(l * SB); wdata[32 +: 32] = 32'h0; we[1] = 1'b1;
      addr[2*AW +: AW] = AW'(l * SB); wdata[64 +: 32] = 32'h66; we[2] = 1'b1;
      step(); model[l] = 0;
      rd(0, l * SB, v); chk("R9 release", v, 32'h0);
    end

    // R4: same-cycle read sees pre-write state
    addr[0 +: AW] = AW'(2 * SB); wdata[0 +: 32] = 32'h31; we[0] = 1'b1;
    addr[AW +: AW] = AW'(2 * SB); re[1] = 1'b1;
    step();
    chk("R4 pre-write", rdata[32 +: 32], 32'h0);
    rd(1, 2 * SB, v); chk("R4", v, 32'h31);

    // R8: reset while locks held
    rst_n = 1'b0; #5 rst_n = 1'b1;
    for (int l = 0; l < NL; l++) model[l] = 0;
    @(negedge clk);
    verify_all("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule